// File: doc/BRIEF.md
# Dual-Controller Octal Memory Port Multiplexer

This block sits between two octal serial memory controllers and two external memory ports. Each controller presents a serial clock, an active-low chip select, a 2-bit chip-select selection, data outputs with per-bit output enables, and receives read data and a read strobe back. A 32-bit control register sets the routing. It can run straight, crossed, or shared, where both controllers use one port. It also holds a chip-select selection override and the idle gap inserted between shared-port transactions.

In a shared mode the controllers must raise a request and wait for a grant before starting a transaction. The grant is held for the whole transaction, which lasts from the controller's chip select going low until it returns high. After the release, the port stays idle for the programmed gap. When both controllers wait, the grant alternates between them. The control register can be written only while both controllers report themselves disabled. A refused write leaves the register untouched and raises a flag.

Top module: `octmem_port_mux`

## Requirements
- R1: After reset the control register reads 0 (straight routing, no override, gap field 0), both grant outputs are high and the reject flag is low.
- R2: The register stores only bits [1:0] (mode, bit 0 = shared enable), bit 4 (override enable), bits [6:5] (override value) and bits [23:16] (gap field); all other bits read back 0.
- R3: Mode 0 connects controller 0 to port 0 and controller 1 to port 1, in both directions.
- R4: Mode 2 connects controller 0 to port 1 and controller 1 to port 0, in both directions.
- R5: Mode 1 shares port 0 and mode 3 shares port 1. In either shared mode the unused port holds chip select high, clock low, data and output enables at zero and selection at 0.
- R6: In a shared mode, a lone request is granted at the next clock edge. The grant is held until that controller's chip select returns high after having been low. While nothing is granted, the shared port is idle as in R5.
- R7: After a shared transaction ends, the grant outputs stay low for exactly (gap field + 1) cycles before the next grant.
- R8: When both controllers request in the same idle cycle, the one not granted last wins. After a register write or reset, controller 0 wins the first tie.
- R9: In a shared mode, the granted controller receives the shared port's read data and strobe. The other controller receives zero data and a low strobe.
- R10: With bit 4 set, every active port drives the value of bits [6:5] as its chip-select selection, instead of the routed controller's selection.
- R11: A register write while either controller-enable input is high is ignored and sets the reject flag. An accepted write clears the flag.
- R12: In modes 0 and 2 both grant outputs are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents |
| cfg_rejected | output | 1 | Last write was refused |
| ctl_en | input | 2 | Controller enabled indications |
| ctl_req | input | 2 | Port requests (shared modes) |
| ctl_gnt | output | 2 | Port grants |
| ctl_sck | input | 2 | Controller serial clocks |
| ctl_cs_n | input | 2 | Controller chip selects, active low |
| ctl_cssel | input | 4 | Controller chip-select selections, 2 bits each |
| ctl_dq_o | input | 2*DW | Controller data outputs |
| ctl_dq_oe | input | 2*DW | Controller data output enables |
| ctl_dq_in | output | 2*DW | Read data returned to controllers |
| ctl_dqs_in | output | 2 | Read strobe returned to controllers |
| prt_sck | output | 2 | Port serial clocks |
| prt_cs_n | output | 2 | Port chip selects, active low |
| prt_cssel | output | 4 | Port chip-select selections |
| prt_dq_o | output | 2*DW | Port data outputs |
| prt_dq_oe | output | 2*DW | Port data output enables |
| prt_dq_i | input | 2*DW | Port read data |
| prt_dqs_i | input | 2 | Port read strobes |

## Verification
The bench builds the block with the default lane width of 8. Each controller and port drives a distinct byte, so any wrong lane or swapped direction shows up as a wrong value. The gap field is run at 3 and at 0. This covers both a multi-cycle dead time and the shortest one-cycle gap, together with the round-robin handover between two held requests.

// File: rtl/octmem_port_mux.sv
module octmem_port_mux #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            cfg_rejected,
  input  logic [1:0]      ctl_en,
  input  logic [1:0]      ctl_req,
  output logic [1:0]      ctl_gnt,
  input  logic [1:0]      ctl_sck,
  input  logic [1:0]      ctl_cs_n,
  input  logic [3:0]      ctl_cssel,
  input  logic [2*DW-1:0] ctl_dq_o,
  input  logic [2*DW-1:0] ctl_dq_oe,
  output logic [2*DW-1:0] ctl_dq_in,
  output logic [1:0]      ctl_dqs_in,
  output logic [1:0]      prt_sck,
  output logic [1:0]      prt_cs_n,
  output logic [3:0]      prt_cssel,
  output logic [2*DW-1:0] prt_dq_o,
  output logic [2*DW-1:0] prt_dq_oe,
  input  logic [2*DW-1:0] prt_dq_i,
  input  logic [1:0]      prt_dqs_i
);

  localparam logic [31:0] WR_MASK = 32'h00FF_0073;

  logic [31:0] cr_q;
  logic [1:0]  gnt_q;
  logic        seen_q;
  logic        last_q;
  logic [7:0]  gap_q;

  logic       shared, hi_port, ovr_en, cfg_ok;
  logic [1:0] ovr_val;
  logic       own;

  assign shared  = cr_q[0];
  assign hi_port = cr_q[1];
  assign ovr_en  = cr_q[4];
  assign ovr_val = cr_q[6:5];
  assign cfg_ok  = cfg_we && (ctl_en == 2'b00);
  assign own     = gnt_q[1];

  assign cfg_rdata = cr_q;
  assign ctl_gnt   = shared ? gnt_q : 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q         <= '0;
      cfg_rejected <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_ok) begin
        cr_q         <= cfg_wdata & WR_MASK;
        cfg_rejected <= 1'b0;
      end else begin
        cfg_rejected <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_ok || !shared) begin
      gnt_q  <= '0;
      seen_q <= 1'b0;
      gap_q  <= '0;
      last_q <= 1'b1;
    end else if (|gnt_q) begin
      if (!ctl_cs_n[own]) begin
        seen_q <= 1'b1;
      end else if (seen_q) begin
        gnt_q  <= '0;
        seen_q <= 1'b0;
        gap_q  <= cr_q[23:16];
        last_q <= own;
      end
    end else if (gap_q != 8'd0) begin
      gap_q <= gap_q - 8'd1;
    end else if (ctl_req == 2'b11) begin
      gnt_q <= last_q ? 2'b01 : 2'b10;
    end else if (ctl_req != 2'b00) begin
      gnt_q <= ctl_req;
    end
  end

  logic [1:0] src, act, rt, pix;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      src[p] = shared ? own : (1'(p) ^ hi_port);
      act[p] = shared ? ((1'(p) == hi_port) && (|gnt_q)) : 1'b1;
      prt_sck[p]  = act[p] & ctl_sck[src[p]];
      prt_cs_n[p] = !act[p] | ctl_cs_n[src[p]];
      prt_cssel[p*2 +: 2] = !act[p] ? 2'b00 :
                            (ovr_en ? ovr_val : ctl_cssel[int'(src[p])*2 +: 2]);
      prt_dq_o[p*DW +: DW]  = act[p] ? ctl_dq_o[int'(src[p])*DW +: DW]  : '0;
      prt_dq_oe[p*DW +: DW] = act[p] ? ctl_dq_oe[int'(src[p])*DW +: DW] : '0;
    end
    for (int c = 0; c < 2; c++) begin
      rt[c]  = shared ? gnt_q[c] : 1'b1;
      pix[c] = shared ? hi_port : (1'(c) ^ hi_port);
      ctl_dq_in[c*DW +: DW] = rt[c] ? prt_dq_i[int'(pix[c])*DW +: DW] : '0;
      ctl_dqs_in[c] = rt[c] & prt_dqs_i[pix[c]];
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R6

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && !cfg_we && (|gnt_q) && !ctl_cs_n[own]) |=> $stable(gnt_q)); // R6

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != 8'd0) |=> (gnt_q == 2'b00)); // R7

  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    shared |-> (prt_cs_n[!hi_port] && (prt_dq_oe[int'(!hi_port)*DW +: DW] == '0))); // R5

  AST_NO_GNT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (shared && !gnt_q[0]) |-> (ctl_dqs_in[0] == 1'b0 && ctl_dq_in[DW-1:0] == '0)); // R9

  AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (ctl_en != 2'b00)) |=> ($stable(cr_q) && cfg_rejected)); // R11

endmodule

// File: tb/octmem_port_mux_tb.sv
module octmem_port_mux_tb_top;
  localparam int DW = 8;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic cfg_rejected;
  logic [1:0] ctl_en = '0, ctl_req = '0, ctl_gnt;
  logic [1:0] ctl_sck = 2'b01, ctl_cs_n = 2'b11;
  logic [3:0] ctl_cssel = 4'b1101;
  logic [2*DW-1:0] ctl_dq_o = 16'hB2A1, ctl_dq_oe = 16'hF00F, ctl_dq_in;
  logic [1:0] ctl_dqs_in;
  logic [1:0] prt_sck, prt_cs_n;
  logic [3:0] prt_cssel;
  logic [2*DW-1:0] prt_dq_o, prt_dq_oe;
  logic [2*DW-1:0] prt_dq_i = 16'h2211;
  logic [1:0] prt_dqs_i = 2'b01;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  octmem_port_mux #(.DW(DW)) dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_gnt(output int lows);
    lows = 0;
    for (int i = 0; i < 600; i++) begin
      cyc();
      if (ctl_gnt != 2'b00) break;
      lows++;
    end
  endtask

  task automatic t_reset();
    chk("R1 rdata", 64'(cfg_rdata), 64'h0);
    chk("R1 gnt", 64'(ctl_gnt), 64'h3);
    chk("R1 rejected", 64'(cfg_rejected), 64'h0);
  endtask

  task automatic t_fields();
    wr(32'hFFFF_FFF0);
    chk("R2 mask", 64'(cfg_rdata), 64'h00FF_0070);
    wr(32'h0);
    chk("R2 clear", 64'(cfg_rdata), 64'h0);
  endtask

  task automatic t_direct();
    wr(32'h0);
    ctl_cs_n = 2'b10; cyc();
    chk("R3 dq_o", 64'(prt_dq_o), 64'hB2A1);
    chk("R3 oe", 64'(prt_dq_oe), 64'hF00F);
    chk("R3 cs_n", 64'(prt_cs_n), 64'h2);
    chk("R3 sck", 64'(prt_sck), 64'h1);
    chk("R3 cssel", 64'(prt_cssel), 64'hD);
    chk("R3 dq_in", 64'(ctl_dq_in), 64'h2211);
    chk("R3 dqs", 64'(ctl_dqs_in), 64'h1);
    chk("R12 gnt", 64'(ctl_gnt), 64'h3);
  endtask

  task automatic t_crossed();
    wr(32'h2);
    chk("R4 dq_o", 64'(prt_dq_o), 64'hA1B2);
    chk("R4 cs_n", 64'(prt_cs_n), 64'h1);
    chk("R4 sck", 64'(prt_sck), 64'h2);
    chk("R4 cssel", 64'(prt_cssel), 64'h7);
    chk("R4 dq_in", 64'(ctl_dq_in), 64'h1122);
    chk("R4 dqs", 64'(ctl_dqs_in), 64'h2);
    chk("R12 gnt", 64'(ctl_gnt), 64'h3);
  endtask

  task automatic t_override();
    wr(32'h0000_0050);
    chk("R10 cssel", 64'(prt_cssel), 64'hA);
    wr(32'h0);
    chk("R10 off", 64'(prt_cssel), 64'hD);
  endtask

  task automatic t_reject();
    ctl_en = 2'b01;
    wr(32'h0000_0003);
    chk("R11 unchanged", 64'(cfg_rdata), 64'h0);
    chk("R11 flag", 64'(cfg_rejected), 64'h1);
    chk("R11 routing", 64'(prt_dq_o), 64'hB2A1);
    ctl_en = 2'b00;
    wr(32'h0);
    chk("R11 cleared", 64'(cfg_rejected), 64'h0);
  endtask

  task automatic t_shared_gap();
    int lows;
    ctl_cs_n = 2'b11; ctl_req = 2'b00; prt_dq_i = 16'h335A; prt_dqs_i = 2'b11;
    wr(32'h0003_0001);
    chk("R6 idle gnt", 64'(ctl_gnt), 64'h0);
    chk("R6 idle cs", 64'(prt_cs_n), 64'h3);
    chk("R6 idle oe", 64'(prt_dq_oe), 64'h0);
    ctl_req = 2'b01; cyc();
    chk("R6 grant", 64'(ctl_gnt), 64'h1);
    ctl_cs_n = 2'b10; ctl_req = 2'b11; cyc();
    chk("R5 cs_n", 64'(prt_cs_n), 64'h2);
    chk("R5 unused oe", 64'(prt_dq_oe[15:8]), 64'h0);
    chk("R5 unused sck", 64'(prt_sck[1]), 64'h0);
    chk("R9 dq_o", 64'(prt_dq_o), 64'h00A1);
    chk("R9 dq_in", 64'(ctl_dq_in), 64'h005A);
    chk("R9 dqs", 64'(ctl_dqs_in), 64'h1);
    cyc();
    chk("R6 hold", 64'(ctl_gnt), 64'h1);
    ctl_cs_n = 2'b11; ctl_req = 2'b10;
    wait_gnt(lows);
    chk("R7 gap 3", 64'(lows), 64'd4);
    chk("R6 next", 64'(ctl_gnt), 64'h2);
    ctl_cs_n = 2'b01; cyc();
    chk("R9 swap dq_in", 64'(ctl_dq_in), 64'h5A00);
    chk("R9 swap dq_o", 64'(prt_dq_o), 64'h00B2);
    ctl_cs_n = 2'b11; ctl_req = 2'b00; cyc(); cyc();
  endtask

  task automatic t_round_robin();
    int lows;
    ctl_cs_n = 2'b11; ctl_req = 2'b00;
    wr(32'h0000_0003);
    ctl_req = 2'b11; cyc();
    chk("R8 first tie", 64'(ctl_gnt), 64'h1);
    ctl_cs_n = 2'b10; cyc();
    chk("R5 port1 cs", 64'(prt_cs_n), 64'h1);
    chk("R5 port0 idle", 64'(prt_dq_o[7:0]), 64'h0);
    chk("R9 port1 dq", 64'(ctl_dq_in), 64'h0033);
    ctl_cs_n = 2'b11;
    wait_gnt(lows);
    chk("R7 gap 0", 64'(lows), 64'd1);
    chk("R8 alternate", 64'(ctl_gnt), 64'h2);
    ctl_cs_n = 2'b01; cyc();
    ctl_cs_n = 2'b11;
    wait_gnt(lows);
    chk("R8 back", 64'(ctl_gnt), 64'h1);
    ctl_req = 2'b00; cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_fields();
    t_direct();
    t_crossed();
    t_override();
    t_reject();
    t_shared_gap();
    t_round_robin();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule